// File: doc/BRIEF.md
# Tagged Register Access Unit

This block sits beside an integer register file in which every register carries a small metadata tag next to its data word. It executes the instructions that touch those tags: one that copies a register's tag into a data word, one that stamps a computed tag onto a register without changing its data, and ordinary register and immediate adds, whose result tags are derived from the source tags. On jumps it writes the return address into the link register together with a configured link tag. Each instruction's source tags are checked against per-class check masks, and a failing check raises a one-cycle exception pulse and suppresses the writeback.

A 16-bit tag-control register holds four 4-bit fields that steer these actions. Machine-level software writes it outright. Supervisor and user software write it only through bit-wise enable masks that machine level sets, so each lower level can change exactly the bits granted to it. Results and the exception appear one clock after the instruction is presented. A control-register write takes effect one clock after it is presented, and an instruction issued in the same cycle as the write still sees the old contents.

Top module: `tagged_reg_unit`

## Requirements
- R1: After reset, res_valid, res_rd, res_val, res_tag, tag_exc and tag_ctrl are all zero, and both enable masks are zero.
- R2: Tag read (instr_op 3) yields res_val equal to rs1_tag zero-extended and res_tag equal to 0.
- R3: Tag write (instr_op 4) yields res_val equal to rd_old_val and res_tag equal to the low 4 bits of rs1_val plus imm sign-extended from bit 11.
- R4: Register add (instr_op 1) yields rs1_val+rs2_val with tag (rs1_tag | rs2_tag) & prop, and immediate add (instr_op 5) yields rs1_val+sext(imm) with tag rs1_tag & prop. Here prop is tag_ctrl[11:8].
- R5: For instr_op 1 the check fails when (rs1_tag | rs2_tag) & tag_ctrl[3:0] is non-zero. For instr_op 5 it fails when rs1_tag & tag_ctrl[3:0] is non-zero. A failure drives tag_exc high with res_valid low.
- R6: Jump (instr_op 2) yields res_val equal to link_val and res_tag equal to tag_ctrl[15:12]. It fails its check when rs1_tag & tag_ctrl[7:4] is non-zero, with the same effect as R5.
- R7: When rd_idx is 0, a valid result has res_val 0 and res_tag 0.
- R8: A write with csr_priv 3 replaces the selected register outright. csr_sel 0 selects tag_ctrl, 1 selects the supervisor enable mask and 2 selects the user enable mask.
- R9: A tag_ctrl write with csr_priv 1 gives (wdata & supervisor_enable) | (old & ~supervisor_enable).
- R10: A tag_ctrl write with csr_priv 0 gives (wdata & user_enable) | (old & ~user_enable).
- R11: Enable-mask writes below csr_priv 3 are ignored, and any write with csr_priv 2 is ignored.
- R12: Results and the exception are registered with one cycle of latency. tag_exc lasts exactly one cycle per failing instruction. A cycle with no valid instruction (instr_valid low, or instr_op 0, 6 or 7) gives res_valid 0 and tag_exc 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr_op | input | 3 | 0 none, 1 add, 2 jump, 3 tag read, 4 tag write, 5 add immediate |
| rd_idx | input | 5 | Destination register index |
| rs1_val | input | 32 | Source 1 data |
| rs1_tag | input | 4 | Source 1 tag |
| rs2_val | input | 32 | Source 2 data |
| rs2_tag | input | 4 | Source 2 tag |
| rd_old_val | input | 32 | Current destination data, kept by tag write |
| imm | input | 12 | Immediate, sign-extended |
| link_val | input | 32 | Return address for jumps |
| csr_we | input | 1 | Control register write strobe |
| csr_sel | input | 2 | 0 tag control, 1 supervisor enable, 2 user enable, 3 none |
| csr_priv | input | 2 | Writer privilege: 0 user, 1 supervisor, 3 machine, 2 reserved |
| csr_wdata | input | 16 | Write data |
| res_valid | output | 1 | Writeback of res_val/res_tag to res_rd |
| res_rd | output | 5 | Destination index of the result |
| res_val | output | 32 | Destination data |
| res_tag | output | 4 | Destination tag |
| tag_ctrl | output | 16 | Current tag-control register |
| tag_exc | output | 1 | Tag check failure pulse |

## Verification
A corrupted tag-control bit shows up at tag_ctrl in the cycle after the write that caused it. It also changes every later add tag, link tag or check result that depends on that field. A wrong enable mask has no direct output, so it shows only on the next supervisor or user write, which then lets through or blocks bits it should not. A datapath fault shows up in the result registers one cycle after the instruction, and sweeping every pair of source tags exposes any single bit of propagation or check logic that is stuck or swapped.

// File: rtl/trau_pkg.sv
package trau_pkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ADD  = 3'd1,
    OP_JUMP = 3'd2,
    OP_TRD  = 3'd3,
    OP_TWR  = 3'd4,
    OP_ADDI = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    PRV_USER  = 2'd0,
    PRV_SUPER = 2'd1,
    PRV_RSVD  = 2'd2,
    PRV_MACH  = 2'd3
  } prv_e;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_SEN  = 2'd1,
    SEL_UEN  = 2'd2,
    SEL_NONE = 2'd3
  } csel_e;
endpackage

// File: rtl/trau_ctrl_reg.sv
module trau_ctrl_reg
  import trau_pkg::*;
#(
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic [1:0]        csr_priv,
  input  logic [CTRL_W-1:0] csr_wdata,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CTRL_W-1:0] ctrl_q, sen_q, uen_q;
  logic [CTRL_W-1:0] ctrl_d;

  // Bit-wise merge under an enable mask.
  function automatic logic [CTRL_W-1:0] masked_merge(
    input logic [CTRL_W-1:0] old_v,
    input logic [CTRL_W-1:0] new_v,
    input logic [CTRL_W-1:0] en
  );
    return (new_v & en) | (old_v & ~en);
  endfunction

  // Named write events.
  logic sel_ctrl, wr_ctrl_m, wr_ctrl_s, wr_ctrl_u, wr_sen, wr_uen;
  assign sel_ctrl  = csr_we && (csr_sel == SEL_CTRL);
  assign wr_ctrl_m = sel_ctrl && (csr_priv == PRV_MACH);
  assign wr_ctrl_s = sel_ctrl && (csr_priv == PRV_SUPER);
  assign wr_ctrl_u = sel_ctrl && (csr_priv == PRV_USER);
  assign wr_sen    = csr_we && (csr_sel == SEL_SEN) && (csr_priv == PRV_MACH);
  assign wr_uen    = csr_we && (csr_sel == SEL_UEN) && (csr_priv == PRV_MACH);

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl_m)      ctrl_d = csr_wdata;
    else if (wr_ctrl_s) ctrl_d = masked_merge(ctrl_q, csr_wdata, sen_q);
    else if (wr_ctrl_u) ctrl_d = masked_merge(ctrl_q, csr_wdata, uen_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      sen_q  <= '0;
      uen_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      if (wr_sen) sen_q <= csr_wdata;
      if (wr_uen) uen_q <= csr_wdata;
    end
  end

  assign ctrl_o = ctrl_q;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!csr_we || csr_priv == PRV_RSVD) |=> $stable(ctrl_q)); // R11
  AST_SUPER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_priv == PRV_SUPER && csr_sel == SEL_CTRL)
      |=> ((ctrl_q ^ $past(ctrl_q)) & ~$past(sen_q)) == '0); // R9
  AST_USER_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_priv == PRV_USER && csr_sel == SEL_CTRL)
      |=> ((ctrl_q ^ $past(ctrl_q)) & ~$past(uen_q)) == '0); // R10
  AST_EN_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_priv != PRV_MACH) |=> ($stable(sen_q) && $stable(uen_q))); // R11
  AST_MACH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_priv == PRV_MACH && csr_sel == SEL_CTRL)
      |=> ctrl_q == $past(csr_wdata)); // R8
endmodule

// File: rtl/trau_tag_check.sv
module trau_tag_check
  import trau_pkg::*;
#(
  parameter int TW = 4
) (
  input  logic          active,
  input  logic [2:0]    op,
  input  logic [TW-1:0] rs1_tag,
  input  logic [TW-1:0] rs2_tag,
  input  logic [TW-1:0] add_mask,
  input  logic [TW-1:0] jmp_mask,
  output logic          fail
);
  logic [TW-1:0] hit;

  always_comb begin
    hit = '0;
    if (active) begin
      case (op_e'(op))
        OP_ADD:  hit = (rs1_tag | rs2_tag) & add_mask;
        OP_ADDI: hit = rs1_tag & add_mask;
        OP_JUMP: hit = rs1_tag & jmp_mask;
        default: hit = '0;
      endcase
    end
  end

  assign fail = |hit;
endmodule

// File: rtl/trau_datapath.sv
module trau_datapath
  import trau_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int TW    = 4,
  parameter int IMM_W = 12,
  parameter int RI_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic [2:0]       op,
  input  logic [RI_W-1:0]  rd_idx,
  input  logic [XLEN-1:0]  rs1_val,
  input  logic [TW-1:0]    rs1_tag,
  input  logic [XLEN-1:0]  rs2_val,
  input  logic [TW-1:0]    rs2_tag,
  input  logic [XLEN-1:0]  rd_old_val,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0]  link_val,
  input  logic [TW-1:0]    prop_mask,
  input  logic [TW-1:0]    link_tag,
  input  logic             chk_fail,
  output logic             res_valid_o,
  output logic [RI_W-1:0]  res_rd_o,
  output logic [XLEN-1:0]  res_val_o,
  output logic [TW-1:0]    res_tag_o,
  output logic             exc_o
);
  localparam int EXT_W = XLEN - IMM_W;

  function automatic logic [XLEN-1:0] sext_imm(input logic [IMM_W-1:0] v);
    return {{EXT_W{v[IMM_W-1]}}, v};
  endfunction

  // Shared adder: second operand is rs2 or the sign-extended immediate.
  logic [XLEN-1:0] opb, sum;
  logic use_imm;
  assign use_imm = (op_e'(op) == OP_ADDI) || (op_e'(op) == OP_TWR);
  assign opb     = use_imm ? sext_imm(imm) : rs2_val;
  assign sum     = rs1_val + opb;

  logic            is_op, do_wb, rd_zero;
  logic [XLEN-1:0] val_d;
  logic [TW-1:0]   tag_d;

  always_comb begin
    is_op = active;
    val_d = '0;
    tag_d = '0;
    case (op_e'(op))
      OP_ADD:  begin val_d = sum;      tag_d = (rs1_tag | rs2_tag) & prop_mask; end
      OP_ADDI: begin val_d = sum;      tag_d = rs1_tag & prop_mask; end
      OP_JUMP: begin val_d = link_val; tag_d = link_tag; end
      OP_TRD:  begin val_d = {{(XLEN-TW){1'b0}}, rs1_tag}; tag_d = '0; end
      OP_TWR:  begin val_d = rd_old_val; tag_d = sum[TW-1:0]; end
      default: is_op = 1'b0;
    endcase
  end

  assign rd_zero = (rd_idx == '0);
  assign do_wb   = is_op && !chk_fail;

  logic [2:0] op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_o <= 1'b0;
      res_rd_o    <= '0;
      res_val_o   <= '0;
      res_tag_o   <= '0;
      exc_o       <= 1'b0;
      op_q        <= '0;
    end else begin
      res_valid_o <= do_wb;
      exc_o       <= is_op && chk_fail;
      op_q        <= is_op ? op : 3'd0;
      if (do_wb) begin
        res_rd_o  <= rd_idx;
        res_val_o <= rd_zero ? '0 : val_d;
        res_tag_o <= rd_zero ? '0 : tag_d;
      end
    end
  end

  AST_FAIL_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    exc_o |-> !res_valid_o); // R5
  AST_X0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && res_rd_o == '0) |-> (res_val_o == '0 && res_tag_o == '0)); // R7
  AST_TRD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid_o && op_q == 3'(OP_TRD)) |-> res_tag_o == '0); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (!res_valid_o && !exc_o)); // R12
endmodule

// File: rtl/tagged_reg_unit.sv
module tagged_reg_unit
  import trau_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int TW    = 4,
  parameter int IMM_W = 12,
  parameter int RI_W  = 5,
  parameter int NFLD  = 4,
  localparam int CTRL_W = NFLD * TW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [2:0]        instr_op,
  input  logic [RI_W-1:0]   rd_idx,
  input  logic [XLEN-1:0]   rs1_val,
  input  logic [TW-1:0]     rs1_tag,
  input  logic [XLEN-1:0]   rs2_val,
  input  logic [TW-1:0]     rs2_tag,
  input  logic [XLEN-1:0]   rd_old_val,
  input  logic [IMM_W-1:0]  imm,
  input  logic [XLEN-1:0]   link_val,
  input  logic              csr_we,
  input  logic [1:0]        csr_sel,
  input  logic [1:0]        csr_priv,
  input  logic [CTRL_W-1:0] csr_wdata,
  output logic              res_valid,
  output logic [RI_W-1:0]   res_rd,
  output logic [XLEN-1:0]   res_val,
  output logic [TW-1:0]     res_tag,
  output logic [CTRL_W-1:0] tag_ctrl,
  output logic              tag_exc
);
  // Field order inside tag_ctrl: add check, jump check, propagate, link tag.
  localparam int F_ADD  = 0;
  localparam int F_JMP  = 1;
  localparam int F_PROP = 2;
  localparam int F_LINK = 3;

  logic [CTRL_W-1:0] ctrl;
  logic [TW-1:0]     fld [NFLD];
  logic              chk_fail;

  for (genvar g = 0; g < NFLD; g++) begin : g_fld
    assign fld[g] = ctrl[g*TW +: TW];
  end

  trau_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_sel(csr_sel),
    .csr_priv(csr_priv), .csr_wdata(csr_wdata), .ctrl_o(ctrl)
  );

  trau_tag_check #(.TW(TW)) u_chk (
    .active(instr_valid), .op(instr_op), .rs1_tag(rs1_tag), .rs2_tag(rs2_tag),
    .add_mask(fld[F_ADD]), .jmp_mask(fld[F_JMP]), .fail(chk_fail)
  );

  trau_datapath #(.XLEN(XLEN), .TW(TW), .IMM_W(IMM_W), .RI_W(RI_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .active(instr_valid), .op(instr_op),
    .rd_idx(rd_idx), .rs1_val(rs1_val), .rs1_tag(rs1_tag),
    .rs2_val(rs2_val), .rs2_tag(rs2_tag), .rd_old_val(rd_old_val),
    .imm(imm), .link_val(link_val), .prop_mask(fld[F_PROP]),
    .link_tag(fld[F_LINK]), .chk_fail(chk_fail),
    .res_valid_o(res_valid), .res_rd_o(res_rd), .res_val_o(res_val),
    .res_tag_o(res_tag), .exc_o(tag_exc)
  );

  assign tag_ctrl = ctrl;

  AST_EXC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (tag_exc && !(instr_valid && chk_fail)) |=> !tag_exc); // R12
endmodule

// File: tb/tb_tagged_reg_unit.sv
module tb_tagged_reg_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        instr_valid = 0;
  logic [2:0]  instr_op = 0;
  logic [4:0]  rd_idx = 0;
  logic [31:0] rs1_val = 0, rs2_val = 0, rd_old_val = 0, link_val = 0;
  logic [3:0]  rs1_tag = 0, rs2_tag = 0;
  logic [11:0] imm = 0;
  logic        csr_we = 0;
  logic [1:0]  csr_sel = 0, csr_priv = 0;
  logic [15:0] csr_wdata = 0;
  logic        res_valid, tag_exc;
  logic [4:0]  res_rd;
  logic [31:0] res_val;
  logic [3:0]  res_tag;
  logic [15:0] tag_ctrl;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] m_ctrl, m_sen, m_uen;

  tagged_reg_unit dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_op(input int op, input int rd, input logic [31:0] v1, input logic [3:0] t1,
                        input logic [31:0] v2, input logic [3:0] t2, input logic [31:0] old,
                        input logic [11:0] im, input logic [31:0] lk);
    instr_valid = 1; instr_op = 3'(op); rd_idx = 5'(rd);
    rs1_val = v1; rs1_tag = t1; rs2_val = v2; rs2_tag = t2;
    rd_old_val = old; imm = im; link_val = lk;
    @(posedge clk); #1;
    instr_valid = 0; instr_op = 0;
  endtask

  task automatic csr_wr(input int sel, input int prv, input logic [15:0] d);
    csr_we = 1; csr_sel = 2'(sel); csr_priv = 2'(prv); csr_wdata = d;
    @(posedge clk); #1;
    csr_we = 0;
    // bench model of the control registers
    if (prv == 3) begin
      if (sel == 0) m_ctrl = d;
      else if (sel == 1) m_sen = d;
      else if (sel == 2) m_uen = d;
    end else if (prv == 1 && sel == 0) m_ctrl = (m_ctrl & ~m_sen) | (d & m_sen);
    else if (prv == 0 && sel == 0) m_ctrl = (m_ctrl & ~m_uen) | (d & m_uen);
  endtask

  function automatic logic [31:0] sx(input logic [11:0] v);
    return 32'($signed(v));
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_ctrl = 0; m_sen = 0; m_uen = 0;
    #(CLK_PERIOD*2 + 1);
    chk(res_valid == 0 && tag_exc == 0 && res_val == 0 && res_tag == 0 && res_rd == 0, "R1 reset outputs", {res_valid, tag_exc, res_tag}, 0);
    chk(tag_ctrl == 0, "R1 reset ctrl", tag_ctrl, 0);
    rst_n = 1;
    @(posedge clk); #1;
    // enable masks at reset are zero: S and U writes change nothing
    csr_wr(1 - 0, 1, 16'hFFFF); // S write to enable: ignored, model unchanged
    csr_wr(0, 1, 16'hFFFF);
    chk(tag_ctrl == 0, "R1 supervisor enable zero after reset", tag_ctrl, 0);
    csr_wr(0, 0, 16'hFFFF);
    chk(tag_ctrl == 0, "R1 user enable zero after reset", tag_ctrl, 0);

    // R8 machine write: link tag A, prop F, no checks
    csr_wr(0, 3, 16'hAF00);
    chk(tag_ctrl == 16'hAF00, "R8 machine write", tag_ctrl, 16'hAF00);

    // R2 tag read sweep
    for (int t = 0; t < 16; t++) begin
      run_op(3, 1 + t, 32'hDEAD0000, 4'(t), 0, 0, 32'h1234, 0, 0);
      chk(res_valid && res_rd == 5'(1 + t) && res_val == 32'(t) && res_tag == 0, "R2 tag read", res_val, t);
    end
    // R7 x0
    run_op(3, 0, 0, 4'h7, 0, 0, 0, 0, 0);
    chk(res_valid && res_val == 0 && res_tag == 0, "R7 x0 tag read", {res_val[27:0], res_tag}, 0);
    run_op(1, 0, 32'h55, 4'hF, 32'h66, 4'h1, 0, 0, 0);
    chk(res_valid && res_val == 0 && res_tag == 0, "R7 x0 add", {res_val[27:0], res_tag}, 0);

    // R3 tag write sweep incl. negative immediates
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        logic [31:0] v1; logic [11:0] im; logic [31:0] s;
        v1 = 32'(a * 37 + 32'h100);
        im = 12'(b * 519 - 1500);
        s  = v1 + sx(im);
        run_op(4, 3, v1, 4'h9, 0, 0, 32'hCAFE0000 + 32'(a), im, 0);
        chk(res_valid && res_val == 32'hCAFE0000 + 32'(a) && res_tag == s[3:0], "R3 tag write", {res_val[27:0], res_tag}, {28'hAFE0000 + 28'(a), s[3:0]});
      end
    end

    // R4 add sweep under two propagate masks
    for (int p = 0; p < 2; p++) begin
      logic [3:0] pm;
      pm = (p == 0) ? 4'hF : 4'h5;
      csr_wr(0, 3, {4'hA, pm, 8'h00});
      for (int t1 = 0; t1 < 16; t1++) begin
        for (int t2 = 0; t2 < 16; t2++) begin
          logic [31:0] v1, v2;
          logic [3:0] et;
          v1 = 32'(t1 * 1000 + 7); v2 = 32'hFFFFFF00 + 32'(t2);
          et = (4'(t1) | 4'(t2)) & pm;
          run_op(1, 5, v1, 4'(t1), v2, 4'(t2), 0, 0, 0);
          chk(res_valid && !tag_exc && res_val == v1 + v2 && res_tag == et, "R4 add", {res_val[27:0], res_tag}, {28'(v1 + v2), et});
        end
      end
    end
    for (int t1 = 0; t1 < 16; t1++) begin
      logic [11:0] im; logic [31:0] ev;
      im = 12'(t1 * 200 - 1600);
      ev = 32'd5000 + sx(im);
      run_op(5, 6, 32'd5000, 4'(t1), 32'hFFFF, 4'hF, 0, im, 0);
      chk(res_valid && res_val == ev && res_tag == (4'(t1) & 4'h5), "R4 add immediate", res_val, ev);
    end

    // R5 add check mask
    csr_wr(0, 3, 16'hAF08);
    for (int t1 = 0; t1 < 16; t1++) begin
      for (int t2 = 0; t2 < 16; t2++) begin
        logic f;
        f = ((4'(t1) | 4'(t2)) & 4'h8) != 0;
        run_op(1, 7, 1, 4'(t1), 2, 4'(t2), 0, 0, 0);
        chk(tag_exc == f && res_valid == !f, "R5 add check", {tag_exc, res_valid}, {f, !f});
      end
    end
    for (int t1 = 0; t1 < 16; t1++) begin
      logic f;
      f = (4'(t1) & 4'h8) != 0;
      run_op(5, 7, 1, 4'(t1), 2, 4'hF, 0, 12'h001, 0);
      chk(tag_exc == f && res_valid == !f, "R5 add immediate check", {tag_exc, res_valid}, {f, !f});
    end

    // R6 jump: link tag, jump check mask 2
    csr_wr(0, 3, 16'hA020);
    for (int t1 = 0; t1 < 16; t1++) begin
      logic f;
      f = (4'(t1) & 4'h2) != 0;
      run_op(2, 1, 32'h8000, 4'(t1), 0, 4'hF, 0, 0, 32'h4000 + 32'(t1));
      if (f) chk(tag_exc && !res_valid, "R6 jump check", {tag_exc, res_valid}, 2'b10);
      else chk(res_valid && !tag_exc && res_val == 32'h4000 + 32'(t1) && res_tag == 4'hA, "R6 jump link", {res_val[27:0], res_tag}, {28'h4000 + 28'(t1), 4'hA});
    end

    // R12 one-cycle pulse and idle behaviour
    run_op(2, 1, 0, 4'h2, 0, 0, 0, 0, 0);
    chk(tag_exc == 1, "R12 exception raised", tag_exc, 1);
    @(posedge clk); #1;
    chk(tag_exc == 0 && res_valid == 0, "R12 exception one cycle", {tag_exc, res_valid}, 0);
    for (int op = 0; op < 8; op++) begin
      if (op == 0 || op == 6 || op == 7) begin
        run_op(op, 4, 1, 4'h2, 1, 4'h2, 0, 0, 0);
        chk(!res_valid && !tag_exc, "R12 non-instruction opcode", {res_valid, tag_exc}, 0);
      end
    end
    instr_op = 3'd3; instr_valid = 0; rs1_tag = 4'h2;
    @(posedge clk); #1;
    chk(!res_valid && !tag_exc, "R12 invalid cycle", {res_valid, tag_exc}, 0);
    instr_op = 0;

    // R9 / R10 masked writes
    csr_wr(1, 3, 16'h0FF0);
    csr_wr(2, 3, 16'h00F3);
    for (int k = 0; k < 16; k++) begin
      logic [15:0] d;
      d = 16'(k * 16'h1357 + 16'h2468);
      csr_wr(0, 1, d);
      chk(tag_ctrl == m_ctrl, "R9 supervisor masked write", tag_ctrl, m_ctrl);
      d = ~d;
      csr_wr(0, 0, d);
      chk(tag_ctrl == m_ctrl, "R10 user masked write", tag_ctrl, m_ctrl);
    end

    // R11 ignored writes
    csr_wr(1, 1, 16'hFFFF);
    csr_wr(2, 0, 16'hFFFF);
    csr_wr(1, 2, 16'hFFFF);
    csr_wr(0, 3, 16'h0000);
    csr_wr(0, 1, 16'hFFFF);
    chk(tag_ctrl == 16'h0FF0, "R11 supervisor enable kept", tag_ctrl, 16'h0FF0);
    csr_wr(0, 0, 16'h0000);
    chk(tag_ctrl == 16'h0F00, "R11 user enable kept", tag_ctrl, 16'h0F00);
    csr_wr(0, 2, 16'h1234);
    chk(tag_ctrl == 16'h0F00 && m_ctrl == 16'h0F00, "R11 reserved privilege ignored", tag_ctrl, 16'h0F00);
    csr_wr(3, 3, 16'hBEEF);
    chk(tag_ctrl == 16'h0F00, "R8 select none", tag_ctrl, 16'h0F00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule